// File: doc/BRIEF.md
# UART Register Front End with Prioritised Interrupt

This block is the software-visible face of a 16450-style serial port. A CPU reaches it through a simple 32-bit bus. The bus carries a byte address, and bits above the lowest two select one of eight word registers. The block does the following:

- It keeps the most recently received byte and the sticky line-status and modem-status flags.
- It passes written bytes to a transmitter as a one-cycle strobe.
- It holds the line-format, modem-control and divisor settings for the serial circuits beside it.
- It raises a single interrupt line, with a readable identification code.

The serial shifter, the baud-rate generator and the parity and framing checks are separate circuits. They feed this block a received byte with a valid strobe, and one-cycle pulses for parity, framing and break errors. A separate modem interface supplies change pulses and current levels for the four modem inputs. The interrupt follows a fixed four-level priority. A line error outranks received data. Received data outranks an empty transmitter, and an empty transmitter outranks a modem change. Reading the data, line-status or modem-status register clears the flags that the read reports.

Top module: `uart_regif`

## Requirements
- R1: After a synchronous reset, `bus_rdata` is 0, `irq` is 0 and `rx_ready` is 1. A read of offset 5 returns 0x60 and a read of offset 2 returns 0x1. `line_cfg`, `modem_ctl` and `baud_div` are 0.
- R2: The register offset is `bus_addr >> 2`, and the two low address bits are ignored. Offsets 0..7 are the following registers:
  - 0: data
  - 1: interrupt enable
  - 2: interrupt identification
  - 3: line format
  - 4: modem control
  - 5: line status
  - 6: modem status
  - 7: divisor

  A write to an offset of 8 or more changes nothing, and a read there returns 0.
- R3: Writes to offsets 1, 3, 4 and 7 store the value:
  - offset 1: `bus_wdata[3:0]`
  - offset 3: `bus_wdata[6:0]`, driven on `line_cfg`
  - offset 4: `bus_wdata[1:0]`, driven on `modem_ctl`
  - offset 7: `bus_wdata[31:0]`, driven on `baud_div`

  The new values take effect in the cycle after the write. A read of any of these four offsets returns 0.
- R4: A write to offset 0 drives `tx_byte` = `bus_wdata[7:0]` in the next cycle, with `tx_strobe` high for exactly that one cycle. `tx_byte` then holds its value.
- R5: A cycle with `rx_valid` high stores `rx_byte` and sets data-ready (line-status bit 0). `rx_ready` is the inverse of data-ready. A read of offset 0 returns the stored byte and clears data-ready. If a byte arrives in the same cycle as that read, data-ready stays set and the read returns the older byte.
- R6: A byte that arrives while data-ready is set, with no data read in that cycle, sets overrun (line-status bit 1) and replaces the stored byte.
- R7: The error pulses set sticky line-status bits: `err_parity` sets bit 2, `err_frame` sets bit 3 and `err_break` sets bit 4. Bits 5 and 6 always read 1, and bit 7 reads 0. A read of offset 5 clears bits 1..4. A set condition in the same cycle as that read leaves its bit set.
- R8: Modem-status bits 3:0 are sticky copies of the `modem_delta` pulses, and a read of offset 6 clears them. A pulse in the same cycle as that read wins over the clear. Bits 7:4 show `modem_level`, registered once.
- R9: The identification code is chosen by the first of these rules that applies:
  1. 0x6 if any of line-status bits 1..4 is set and enable bit 2 is set.
  2. 0x4 if data-ready is set and enable bit 0 is set.
  3. 0x2 if enable bit 1 is set; the transmitter-empty bit is always set.
  4. 0x0 if any of modem-status bits 3:0 is set and enable bit 3 is set.
  5. 0x1 otherwise.
- R10: `irq` is high exactly when the identification code is not 0x1. It follows register state in the same cycle that the state changes.
- R11: Writes to offsets 2, 5 and 6 change no register.
- R12: `bus_rdata` is loaded on the clock edge where `bus_re` is high, with values from before that edge. It holds its value while no read is made. The side effects of a read act on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits above the low two select the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| rx_byte | input | DATA_W | Byte from the receiver |
| rx_valid | input | 1 | Received byte strobe |
| rx_ready | output | 1 | High while no unread byte is held |
| tx_byte | output | DATA_W | Byte for the transmitter |
| tx_strobe | output | 1 | One-cycle pulse when `tx_byte` is new |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_break | input | 1 | Break detected pulse |
| modem_delta | input | 4 | Modem change pulses |
| modem_level | input | 4 | Current modem input levels |
| line_cfg | output | LCR_W | Stored line-format setting |
| modem_ctl | output | MCR_W | Stored modem-control setting |
| baud_div | output | DIV_W | Stored divisor |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_we` and `bus_re` are whole-cycle strobes with a steady address. They also assume that the receiver and error circuits present each event for one clock only. An input held high would count again in every cycle. Under those conditions, the same-cycle rules for overrun and for clear-versus-set become clean one-cycle implications. The stimulus changes inputs only at the falling edge and pulses every event for exactly one cycle. It deliberately presents a byte, an error pulse or a modem pulse in the same cycle as the read that would clear it.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int NREG  = 8;
  localparam int IEN_W = 4;
  localparam int LCR_W = 7;
  localparam int MCR_W = 2;

  typedef enum logic [2:0] {
    OFF_DATA     = 3'd0,
    OFF_IEN      = 3'd1,
    OFF_ID       = 3'd2,
    OFF_LINECFG  = 3'd3,
    OFF_MODEMCTL = 3'd4,
    OFF_LSTAT    = 3'd5,
    OFF_MSTAT    = 3'd6,
    OFF_DIVISOR  = 3'd7
  } reg_off_e;

  // line status bit positions
  localparam int LS_READY   = 0;
  localparam int LS_OVERRUN = 1;
  localparam int LS_PARITY  = 2;
  localparam int LS_FRAME   = 3;
  localparam int LS_BREAK   = 4;
  localparam int LS_TXHOLD  = 5;
  localparam int LS_TXIDLE  = 6;

  // interrupt enable bit positions
  localparam int EN_RXDATA = 0;
  localparam int EN_TXHOLD = 1;
  localparam int EN_LINE   = 2;
  localparam int EN_MODEM  = 3;

  // identification codes
  localparam logic [2:0] ID_LINE  = 3'h6;
  localparam logic [2:0] ID_RX    = 3'h4;
  localparam logic [2:0] ID_TX    = 3'h2;
  localparam logic [2:0] ID_MODEM = 3'h0;
  localparam logic [2:0] ID_NONE  = 3'h1;

endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel
);

  localparam int OFF_W = ADDR_W - 2;

  logic [OFF_W-1:0] word_off;
  logic             in_map;
  logic             unused_lowbits;

  assign word_off       = bus_addr[ADDR_W-1:2];
  assign unused_lowbits = ^bus_addr[1:0];
  assign in_map         = (word_off < OFF_W'(NREG));

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    logic hit;
    assign hit       = in_map && (word_off == OFF_W'(g));
    assign wr_sel[g] = hit && bus_we;
    assign rd_sel[g] = hit && bus_re;
  end

endmodule

// File: rtl/uart_regif_status.sv
module uart_regif_status
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              rd_data,
  input  logic              rd_lstat,
  input  logic              rd_mstat,
  input  logic              err_parity,
  input  logic              err_frame,
  input  logic              err_break,
  input  logic [3:0]        modem_delta,
  input  logic [3:0]        modem_level,
  output logic [DATA_W-1:0] rx_hold,
  output logic [7:0]        lstat,
  output logic [7:0]        mstat
);

  logic       ready_q, ovr_q, par_q, frm_q, brk_q;
  logic [3:0] dlt_q, lvl_q;
  logic       ovr_set;

  assign ovr_set = rx_valid && ready_q && !rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      par_q   <= 1'b0;
      frm_q   <= 1'b0;
      brk_q   <= 1'b0;
      dlt_q   <= '0;
      lvl_q   <= '0;
    end else begin
      if (rx_valid) begin
        rx_hold <= rx_byte;
        ready_q <= 1'b1;
      end else if (rd_data) begin
        ready_q <= 1'b0;
      end
      ovr_q <= ovr_set    || (ovr_q && !rd_lstat);
      par_q <= err_parity || (par_q && !rd_lstat);
      frm_q <= err_frame  || (frm_q && !rd_lstat);
      brk_q <= err_break  || (brk_q && !rd_lstat);
      dlt_q <= modem_delta | (rd_mstat ? 4'h0 : dlt_q);
      lvl_q <= modem_level;
    end
  end

  always_comb begin
    lstat             = '0;
    lstat[LS_READY]   = ready_q;
    lstat[LS_OVERRUN] = ovr_q;
    lstat[LS_PARITY]  = par_q;
    lstat[LS_FRAME]   = frm_q;
    lstat[LS_BREAK]   = brk_q;
    lstat[LS_TXHOLD]  = 1'b1;
    lstat[LS_TXIDLE]  = 1'b1;
  end

  assign mstat = {lvl_q, dlt_q};

endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
  import uart_regif_pkg::*;
(
  input  logic [5:0]       lstat,
  input  logic [3:0]       mdelta,
  input  logic [IEN_W-1:0] ien,
  output logic [2:0]       id_code,
  output logic             irq
);

  logic want_line, want_rx, want_tx, want_modem;

  assign want_line  = (|lstat[LS_BREAK:LS_OVERRUN]) && ien[EN_LINE];
  assign want_rx    = lstat[LS_READY] && ien[EN_RXDATA];
  assign want_tx    = lstat[LS_TXHOLD] && ien[EN_TXHOLD];
  assign want_modem = (|mdelta) && ien[EN_MODEM];

  always_comb begin
    if (want_line)       id_code = ID_LINE;
    else if (want_rx)    id_code = ID_RX;
    else if (want_tx)    id_code = ID_TX;
    else if (want_modem) id_code = ID_MODEM;
    else                 id_code = ID_NONE;
  end

  assign irq = want_line | want_rx | want_tx | want_modem;

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_strobe,
  input  logic              err_parity,
  input  logic              err_frame,
  input  logic              err_break,
  input  logic [3:0]        modem_delta,
  input  logic [3:0]        modem_level,
  output logic [LCR_W-1:0]  line_cfg,
  output logic [MCR_W-1:0]  modem_ctl,
  output logic [DIV_W-1:0]  baud_div,
  output logic              irq
);

  logic [NREG-1:0]   wr_sel, rd_sel;
  logic [DATA_W-1:0] rx_hold;
  logic [7:0]        lsr_q, msr_q;
  logic [2:0]        iir_code;
  logic [IEN_W-1:0]  ier_q;
  logic [31:0]       rd_next;

  uart_regif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .wr_sel   (wr_sel),
    .rd_sel   (rd_sel)
  );

  uart_regif_status #(.DATA_W(DATA_W)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .rx_byte     (rx_byte),
    .rx_valid    (rx_valid),
    .rd_data     (rd_sel[OFF_DATA]),
    .rd_lstat    (rd_sel[OFF_LSTAT]),
    .rd_mstat    (rd_sel[OFF_MSTAT]),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_break   (err_break),
    .modem_delta (modem_delta),
    .modem_level (modem_level),
    .rx_hold     (rx_hold),
    .lstat       (lsr_q),
    .mstat       (msr_q)
  );

  uart_regif_irq u_irq (
    .lstat   (lsr_q[5:0]),
    .mdelta  (msr_q[3:0]),
    .ien     (ier_q),
    .id_code (iir_code),
    .irq     (irq)
  );

  logic unused_lsr_hi;
  assign unused_lsr_hi = ^lsr_q[7:6];
  assign rx_ready = !lsr_q[LS_READY];

  // configuration and transmit registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q     <= '0;
      line_cfg  <= '0;
      modem_ctl <= '0;
      baud_div  <= '0;
      tx_byte   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      if (wr_sel[OFF_IEN])      ier_q     <= bus_wdata[IEN_W-1:0];
      if (wr_sel[OFF_LINECFG])  line_cfg  <= bus_wdata[LCR_W-1:0];
      if (wr_sel[OFF_MODEMCTL]) modem_ctl <= bus_wdata[MCR_W-1:0];
      if (wr_sel[OFF_DIVISOR])  baud_div  <= bus_wdata[DIV_W-1:0];
      tx_strobe <= wr_sel[OFF_DATA];
      if (wr_sel[OFF_DATA])     tx_byte   <= bus_wdata[DATA_W-1:0];
    end
  end

  // registered read path
  always_comb begin
    rd_next = '0;
    if (rd_sel[OFF_DATA])  rd_next[DATA_W-1:0] = rx_hold;
    if (rd_sel[OFF_ID])    rd_next[2:0]        = iir_code;
    if (rd_sel[OFF_LSTAT]) rd_next[7:0]        = lsr_q;
    if (rd_sel[OFF_MSTAT]) rd_next[7:0]        = msr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] tx_byte,
  input logic              tx_strobe,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_break,
  input logic [LCR_W-1:0]  line_cfg,
  input logic              irq,
  input logic [7:0]        lsr_q,
  input logic [2:0]        iir_code,
  input logic [IEN_W-1:0]  ier_q
);

  logic [ADDR_W-3:0] off;
  logic              unused_chk;
  logic              any_err;
  assign off        = bus_addr[ADDR_W-1:2];
  assign unused_chk = ^bus_addr[1:0];
  assign any_err    = err_parity || err_frame || err_break;

  p_cfg_store_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && off == 3) |=> (line_cfg == $past(bus_wdata[LCR_W-1:0])));

  p_tx_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && off == 0) |=> (tx_strobe && tx_byte == $past(bus_wdata[DATA_W-1:0])));

  p_tx_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && off == 0) |=> !tx_strobe);

  p_ready_drop_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_ready);

  p_overrun_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !(bus_re && off == 0)) |=> lsr_q[LS_OVERRUN]);

  p_lsr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_re && off == 5 && !rx_valid && !any_err) |=> (lsr_q[4:1] == 4'h0));

  p_line_first_r9: assert property (@(posedge clk) disable iff (rst)
    ((|lsr_q[4:1]) && ier_q[EN_LINE]) |-> (iir_code == ID_LINE));

  p_irq_code_r10: assert property (@(posedge clk) disable iff (rst)
    irq == (iir_code != ID_NONE));

  p_ro_lsr_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_we && off == 5 && !bus_re && !rx_valid && !any_err) |=> $stable(lsr_q));

endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_byte    (tx_byte),
  .tx_strobe  (tx_strobe),
  .err_parity (err_parity),
  .err_frame  (err_frame),
  .err_break  (err_break),
  .line_cfg   (line_cfg),
  .irq        (irq),
  .lsr_q      (lsr_q),
  .iir_code   (iir_code),
  .ier_q      (ier_q)
);

// File: tb/uart_regif_tb.sv
`timescale 1ns/1ps
module uart_regif_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_strobe;
  logic        err_parity = 1'b0, err_frame = 1'b0, err_break = 1'b0;
  logic [3:0]  modem_delta = '0, modem_level = '0;
  logic [6:0]  line_cfg;
  logic [1:0]  modem_ctl;
  logic [31:0] baud_div;
  logic        irq;

  always #4 clk = ~clk;

  uart_regif u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_byte(tx_byte), .tx_strobe(tx_strobe),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .modem_delta(modem_delta), .modem_level(modem_level),
    .line_cfg(line_cfg), .modem_ctl(modem_ctl), .baud_div(baud_div),
    .irq(irq)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string tag_force = "";

  // behavioural reference state
  int m_rx, m_dr, m_oe, m_pe, m_fe, m_bi, m_dlt, m_lvl;
  int m_ier, m_lcr, m_mcr, m_div, m_rdata, m_txb, m_txs;
  string m_rtag = "R1";

  function automatic int m_id();
    if (((m_oe | m_pe | m_fe | m_bi) != 0) && (m_ier & 4)) return 6;
    if (m_dr && (m_ier & 1)) return 4;
    if (m_ier & 2) return 2;
    if (m_dlt != 0 && (m_ier & 8)) return 0;
    return 1;
  endfunction

  function automatic int m_lsr();
    return 32'h60 | m_dr | (m_oe << 1) | (m_pe << 2) | (m_fe << 3) | (m_bi << 4);
  endfunction

  function automatic string tag_of(int off);
    case (off)
      0: return "R5";
      1, 3, 4, 7: return "R3";
      2: return "R9";
      5: return "R7";
      6: return "R8";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rx = 0; m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
      m_dlt = 0; m_lvl = 0; m_ier = 0; m_lcr = 0; m_mcr = 0; m_div = 0;
      m_rdata = 0; m_txb = 0; m_txs = 0; m_rtag = "R1";
    end else begin
      int off;
      bit rd0, rd5, rd6, ovr;
      off = int'(bus_addr) >> 2;
      rd0 = bus_re && off == 0;
      rd5 = bus_re && off == 5;
      rd6 = bus_re && off == 6;
      if (bus_re) begin
        case (off)
          0: m_rdata = m_rx;
          2: m_rdata = m_id();
          5: m_rdata = m_lsr();
          6: m_rdata = (m_lvl << 4) | m_dlt;
          default: m_rdata = 0;
        endcase
        m_rtag = (tag_force != "") ? tag_force : tag_of(off);
      end else m_rtag = "R12";
      m_txs = (bus_we && off == 0);
      if (m_txs) m_txb = bus_wdata & 255;
      if (bus_we) begin
        case (off)
          1: m_ier = bus_wdata & 15;
          3: m_lcr = bus_wdata & 127;
          4: m_mcr = bus_wdata & 3;
          7: m_div = bus_wdata;
          default: ;
        endcase
      end
      ovr = rx_valid && m_dr && !rd0;
      if (rx_valid) begin m_rx = rx_byte; m_dr = 1; end
      else if (rd0) m_dr = 0;
      m_oe = (ovr || (m_oe && !rd5)) ? 1 : 0;
      m_pe = (err_parity || (m_pe && !rd5)) ? 1 : 0;
      m_fe = (err_frame  || (m_fe && !rd5)) ? 1 : 0;
      m_bi = (err_break  || (m_bi && !rd5)) ? 1 : 0;
      m_dlt = modem_delta | (rd6 ? 0 : m_dlt);
      m_lvl = modem_level;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(m_rtag, "rdata", bus_rdata, m_rdata);
      chk("R10", "irq", {31'b0, irq}, (m_id() != 1) ? 1 : 0);
      chk("R5", "rx_ready", {31'b0, rx_ready}, m_dr ? 0 : 1);
      chk("R4", "tx_strobe", {31'b0, tx_strobe}, m_txs);
      chk("R4", "tx_byte", {24'b0, tx_byte}, m_txb);
      chk("R3", "line_cfg", {25'b0, line_cfg}, m_lcr);
      chk("R3", "modem_ctl", {30'b0, modem_ctl}, m_mcr);
      chk("R3", "baud_div", baud_div, m_div);
    end
  end

  task automatic wr(int off, logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(off << 2); bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(int off, string t = "");
    @(negedge clk);
    tag_force = t; bus_addr = 6'(off << 2); bus_re = 1;
    @(negedge clk);
    bus_re = 0; tag_force = "";
  endtask

  task automatic rx(logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset values
    rd(5, "R1"); rd(2, "R1");
    // R3 write-only registers
    wr(3, 32'h5a); wr(4, 32'hff); wr(7, 32'h1234_abcd);
    rd(3); rd(4); rd(7); rd(1);
    // R4 transmit
    wr(0, 32'h1a5); wr(0, 32'h03);
    // R2 decode: unknown offsets and low address bits
    wr(9, 32'hffff_ffff); rd(9, "R2"); rd(15, "R2");
    @(negedge clk); bus_addr = 6'h17; bus_re = 1; tag_force = "R2";
    @(negedge clk); bus_re = 0; tag_force = "";
    @(negedge clk); bus_addr = 6'h0e; bus_wdata = 32'h11; bus_we = 1;
    @(negedge clk); bus_we = 0;
    rd(3, "R2");
    // R5 receive and data read
    rx(8'h3c); rd(5); rd(0); rd(5);
    // R6 overrun
    rx(8'h11); rx(8'h22); rd(5, "R6"); rd(0, "R6"); rd(5, "R6");
    // R5 byte arriving during data read: no overrun
    rx(8'h44);
    @(negedge clk); bus_addr = 0; bus_re = 1; rx_byte = 8'h55; rx_valid = 1;
    @(negedge clk); bus_re = 0; rx_valid = 0;
    rd(5, "R5"); rd(0, "R5");
    // R7 error flags and clear-vs-set
    @(negedge clk); err_parity = 1;
    @(negedge clk); err_parity = 0; err_break = 1;
    @(negedge clk); err_break = 0;
    rd(5); rd(5);
    @(negedge clk); err_frame = 1;
    @(negedge clk); err_frame = 0; bus_addr = 6'(5 << 2); bus_re = 1; err_parity = 1;
    @(negedge clk); bus_re = 0; err_parity = 0;
    rd(5); rd(5);
    // R8 modem status
    @(negedge clk); modem_delta = 4'b0101; modem_level = 4'b1010;
    @(negedge clk); modem_delta = 0;
    rd(6); rd(6);
    @(negedge clk); modem_delta = 4'b0010;
    @(negedge clk); modem_delta = 0;
    @(negedge clk); bus_addr = 6'(6 << 2); bus_re = 1; modem_delta = 4'b1000; modem_level = 4'b0001;
    @(negedge clk); bus_re = 0; modem_delta = 0;
    rd(6); rd(6);
    // R9 priority walk-down
    @(negedge clk); modem_delta = 4'b0001;
    @(negedge clk); modem_delta = 0; err_frame = 1;
    @(negedge clk); err_frame = 0;
    rx(8'h77);
    wr(1, 32'hf); rd(2);
    rd(5); rd(2);
    rd(0); rd(2);
    wr(1, 32'h9); rd(2);
    rd(6); rd(2);
    wr(1, 32'h5); rd(2);
    rx(8'h99); rd(2); wr(1, 32'h0); rd(2);
    // R11 read-only offsets ignore writes
    @(negedge clk); err_break = 1;
    @(negedge clk); err_break = 0;
    wr(5, 32'hff); rd(5, "R11");
    wr(6, 32'hff); rd(6, "R11");
    wr(2, 32'hff); rd(2, "R11");
    wr(1, 32'h2); wr(2, 32'h0); rd(2, "R11");
    rd(0, "R11");
    // R12 hold after reads
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule